// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This unit sits in the execute stage of a small processor. It takes two operands, A and B, and an opcode. From these it produces one of four results: a signed compare, an unsigned compare, the carry-out of an addition, or the 1-based index of the first equal byte lane. The result is captured in a register, and a one-cycle valid pulse marks it.

Both compare modes return the full difference B minus A. When the operands' top bits differ, the top bit of the result is replaced so that it still gives the correct ordering. Software then tests only the top bit: it is 1 when B is less than A. The byte-match mode lets string routines find a matching byte in a word, for example a terminator, in one operation.

Top module: `cmp_bytematch_unit`

## Requirements
- R1: The opcode is decoded as follows: 0 is signed compare, 1 is unsigned compare, 2 is carry, 3 is byte match, and 4 to 7 are unused.
- R2: Signed compare returns B + ~A + 1, which is B minus A modulo 2^W. When the top bits of A and B differ, the top bit of the result is replaced by the top bit of B.
- R3: Unsigned compare returns the same difference. When the top bits of A and B differ, the top bit of the result is replaced by the top bit of A.
- R4: Carry mode returns 1 in bit 0 and zeros above it. Bit 0 is set when B is all ones and carry-in is 1, or when B + carry-in (taken at W bits) is greater than all-ones minus A. Otherwise the result is 0.
- R5: Byte match compares the byte lanes from the most significant lane to the least significant lane. It returns 1 for the top lane, then 2, 3 and 4 for the following lanes, stopping at the first lane where A and B are equal.
- R6: Byte match returns 0 when no lane is equal.
- R7: An unused opcode returns a result of zero, and out_valid is still asserted.
- R8: The result appears on the clock edge that samples in_valid high. out_valid is high for exactly one cycle per accepted input. The result holds its value while in_valid is low.
- R9: After reset, the result is 0 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| op | input | 3 | Operation select |
| opnd_a | input | W | Operand A |
| opnd_b | input | W | Operand B |
| carry_in | input | 1 | Carry-in for carry mode |
| res | output | W | Registered result |
| out_valid | output | 1 | One-cycle result strobe |

## Verification
The bench builds the unit with its default width of 32, which gives four byte lanes. This width covers every lane position in byte match, including the case where no lane matches. It also covers the two carry boundaries: B all ones with carry-in set, and A + B landing exactly on all ones. The compare cases mix operands whose top bits are equal and unequal, so both patch rules are reached. The cases also include the most-negative value and the largest unsigned value.

// File: rtl/cmp_bytematch_unit.sv
module cmp_bytematch_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  output logic [W-1:0] res,
  output logic         out_valid
);
  localparam int LANES = W / 8;
  localparam int IDXW  = $clog2(LANES + 1);

  logic [W-1:0] diff, nxt, lim, bsum;
  logic         msb_ne, cy;
  logic [LANES-1:0] eq;
  logic [IDXW-1:0]  idx;

  assign diff   = opnd_b + ~opnd_a + 1'b1;
  assign msb_ne = opnd_a[W-1] ^ opnd_b[W-1];
  assign lim    = ~opnd_a;
  assign bsum   = opnd_b + {{(W-1){1'b0}}, carry_in};
  assign cy     = (&opnd_b && carry_in) || (lim < bsum);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign eq[g] = opnd_a[W-1-8*g -: 8] == opnd_b[W-1-8*g -: 8];
  end

  always_comb begin
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (eq[i]) idx = IDXW'(i + 1);
  end

  always_comb begin
    nxt = '0;
    unique case (op)
      3'd0: nxt = msb_ne ? {opnd_b[W-1], diff[W-2:0]} : diff;
      3'd1: nxt = msb_ne ? {opnd_a[W-1], diff[W-2:0]} : diff;
      3'd2: nxt = {{(W-1){1'b0}}, cy};
      3'd3: nxt = W'(idx);
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res <= nxt;
    end
  end
endmodule

// File: rtl/cmp_bytematch_unit_chk.sv
module cmp_bytematch_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [2:0]   op,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         carry_in,
  input logic [W-1:0] res,
  input logic         out_valid
);
  // R8
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res));
  // R4
  a_r4_carry_onebit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd2) |=> res[W-1:1] == '0);
  // R7
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[2]) |=> res == '0);
  // R5 R6
  a_r5_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd3) |=> res <= W'(W / 8));
  // R2
  a_r2_signed_order: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd0) |=> res[W-1] == ($signed($past(opnd_b)) < $signed($past(opnd_a))));
  // R3
  a_r3_unsigned_order: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd1) |=> res[W-1] == ($past(opnd_b) < $past(opnd_a)));
endmodule

bind cmp_bytematch_unit cmp_bytematch_unit_chk #(.W(W)) u_chk (.*);

// File: tb/cmp_bytematch_unit_test.sv
module cmp_bytematch_unit_test;
  logic clk = 0, rst_n = 0, in_valid = 0, carry_in = 0;
  logic [2:0] op = 0;
  logic [31:0] a = 0, b = 0, res;
  logic out_valid;
  int runs = 0, fails = 0;

  always #4 clk = ~clk;

  cmp_bytematch_unit #(.W(32)) uut (.clk, .rst_n, .in_valid, .op,
    .opnd_a(a), .opnd_b(b), .carry_in, .res, .out_valid);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] o, logic [31:0] x, logic [31:0] y, logic c);
    @(negedge clk);
    op = o; a = x; b = y; carry_in = c; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset();
    chk("R9 res", res, 0);
    chk("R9 valid", {31'b0, out_valid}, 0);
  endtask

  task automatic t_signed();
    issue(0, 32'd5, 32'd9, 0);           chk("R2 same sign", res, 32'd4);
    issue(0, 32'd9, 32'd5, 0);           chk("R2 neg diff", res, 32'hFFFF_FFFC);
    issue(0, 32'hFFFF_FFFF, 32'd1, 0);   chk("R2 mismatch b pos", res, 32'h0000_0002);
    issue(0, 32'd1, 32'h8000_0000, 0);   chk("R2 mismatch b min", res, 32'hFFFF_FFFF);
  endtask

  task automatic t_unsigned();
    issue(1, 32'hFFFF_FFFF, 32'd1, 0);   chk("R3 mismatch a big", res, 32'h8000_0002);
    issue(1, 32'd1, 32'h8000_0000, 0);   chk("R3 mismatch b big", res, 32'h7FFF_FFFF);
    issue(1, 32'd3, 32'd3, 0);           chk("R3 equal", res, 32'd0);
  endtask

  task automatic t_carry();
    issue(2, 32'd0, 32'hFFFF_FFFF, 1);   chk("R4 b ones cin", res, 32'd1);
    issue(2, 32'h8000_0000, 32'h7FFF_FFFF, 0); chk("R4 exact ones", res, 32'd0);
    issue(2, 32'h8000_0000, 32'h7FFF_FFFF, 1); chk("R4 wrap", res, 32'd1);
    issue(2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0); chk("R4 big", res, 32'd1);
  endtask

  task automatic t_match();
    issue(3, 32'h1122_3344, 32'h1199_9999, 0); chk("R5 lane1", res, 32'd1);
    issue(3, 32'h1122_3344, 32'h0022_3344, 0); chk("R5 lane2 first", res, 32'd2);
    issue(3, 32'h1122_3344, 32'h0000_3300, 0); chk("R5 lane3", res, 32'd3);
    issue(3, 32'h1122_3344, 32'h0000_0044, 0); chk("R5 lane4", res, 32'd4);
    issue(3, 32'h1122_3344, 32'h2233_4411, 0); chk("R6 none", res, 32'd0);
  endtask

  task automatic t_misc();
    issue(1, 32'd2, 32'd7, 0); chk("R1 op1 diff", res, 32'd5);
    issue(5, 32'd2, 32'd7, 0); chk("R7 unused res", res, 32'd0);
    @(negedge clk); op = 0; a = 0; b = 32'd7; in_valid = 1; @(posedge clk); #1;
    chk("R8 valid high", {31'b0, out_valid}, 1);
    chk("R7 R8 result", res, 32'd7);
    @(negedge clk); in_valid = 0; a = 32'd1; @(posedge clk); #1;
    chk("R8 valid one cycle", {31'b0, out_valid}, 0);
    chk("R8 hold", res, 32'd7);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_signed(); t_unsigned(); t_carry(); t_match(); t_misc();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++; runs++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule